// File: doc/BRIEF.md
# Ternary Match Table with Indirect Command Register

This block holds a small ternary match table behind a plain 64-bit register port. Software never touches the table directly. It first stages a 200-bit key and a 200-bit mask across eight 64-bit words. For associated data it stages one 64-bit word instead. It then writes an opcode and an entry index into a single control word. A sequencer carries out the command over several clock cycles. During that time the done flag in the control word reads low. When the command ends the flag rises again, and any result is posted back into the control word or the staging words.

Five commands exist:
- store the staged key and mask into an entry;
- load an entry's key and mask back into the staging words;
- search the table for the staged key;
- store the associated data of an entry;
- load the associated data of an entry.

A search visits one entry per clock cycle, starting at index 0. It stops at the first valid entry whose care bits agree with the staged key. For that reason the lowest matching index always wins.

Top module: `tcam_cmd_ctrl`

## Requirements
- R1: Register words are selected by a word address. Addresses 0 to 3 are key staging words and 4 to 7 are mask staging words. Word 0 holds key bits 199:192 in bits 7:0, and its bits 63:8 always read zero. Word 1 holds 191:128, word 2 holds 127:64 and word 3 holds 63:0. Address 8 is the control word. Any other address reads zero, and writes to it are ignored.
- R2: The control word holds the entry index in bits 9:0, the hit flag in bit 16, the done flag in bit 17 and the opcode in bits 20:18. All other bits read zero.
- R3: After reset the control word reads done=1, hit=0, opcode 000 and index 0. All staging words read zero. Every entry is invalid, so any search misses, including a search for the all-zero key.
- R4: Opcode 000 copies the staged key and mask into the indexed entry and marks the entry valid. Opcode 001 copies that entry's key and mask back into the eight staging words.
- R5: An entry matches a key when every key bit whose stored mask bit is 1 equals the stored key bit. Mask bits of 0 are don't-care. Invalid entries never match.
- R6: Opcode 010 searches the table. On completion hit=1 and the index field holds the lowest matching index. On a miss both hit and the index field read 0.
- R7: Latency is counted in clock edges from the edge that captures the control write. A non-search command sets done 1 edge later. A search that hits entry k sets done after k+1 edges. A search that misses sets done after as many edges as there are entries.
- R8: Opcode 100 stores key staging word 1 as the indexed entry's 64-bit associated data. Opcode 101 returns that data into key staging word 1 and leaves every other staging word alone.
- R9: While a command is in progress, writes to the control word and to the staging words are ignored.
- R10: A control write with an opcode outside the five listed has no effect. Done stays set, and the whole control word reads back unchanged.
- R11: A write or read command whose index is not below the entry count completes normally. It changes no entry and no staging word.
- R12: A control write with a listed opcode, made while idle, clears done and hit from the next cycle until the command finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | ADDR_W (4) | Word address of the register access |
| reg_we | input | 1 | Write strobe, one word per cycle |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for the word at reg_addr, combinational |

## Verification
The bench builds the block with 16 entries, a 10-bit index field and the 200-bit key. With only 16 entries, the last-entry hit and the full-table miss (16-edge latency) can be exercised many times within a short run. The 10-bit index field also leaves room for indices from 16 up to 1023, so out-of-range write and read commands can be driven. Random searches are biased toward keys derived from stored entries with only don't-care bits flipped, so that priority among several matching entries occurs often.

// File: rtl/tcam_pkg.sv
package tcam_pkg;

   typedef enum logic [2:0] {
      OP_PUT_KM  = 3'b000,
      OP_GET_KM  = 3'b001,
      OP_LOOKUP  = 3'b010,
      OP_PUT_AD  = 3'b100,
      OP_GET_AD  = 3'b101
   } tcam_op_e;

   typedef enum logic [1:0] {
      SQ_IDLE,
      SQ_EXEC,
      SQ_SCAN
   } sq_state_e;

   localparam int CW_HIT_BIT  = 16;
   localparam int CW_DONE_BIT = 17;
   localparam int CW_OP_LSB   = 18;
   localparam int CW_OP_W     = 3;

   localparam int STAGE_WORDS = 4;
   localparam int CTRL_ADDR   = 8;

   function automatic logic op_known(input logic [2:0] op);
      return (op == OP_PUT_KM) || (op == OP_GET_KM) || (op == OP_LOOKUP) ||
             (op == OP_PUT_AD) || (op == OP_GET_AD);
   endfunction

endpackage

// File: rtl/tcam_stage.sv
module tcam_stage #(
   parameter int KEY_W  = 200,
   parameter int WORD_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_we,
   input  logic [2:0]        sw_word,
   input  logic [WORD_W-1:0] sw_wdata,
   input  logic              load_km,
   input  logic [KEY_W-1:0]  load_key,
   input  logic [KEY_W-1:0]  load_mask,
   input  logic              load_ad,
   input  logic [WORD_W-1:0] load_data,
   output logic [KEY_W-1:0]  key_flat,
   output logic [KEY_W-1:0]  mask_flat,
   output logic [WORD_W-1:0] ad_word,
   output logic [WORD_W-1:0] sw_rdata
);
   import tcam_pkg::*;

   localparam int TOP_W = KEY_W - (STAGE_WORDS - 1) * WORD_W;

   logic [STAGE_WORDS-1:0][WORD_W-1:0] kview;
   logic [STAGE_WORDS-1:0][WORD_W-1:0] mview;

   for (genvar w = 0; w < STAGE_WORDS; w++) begin : g_word
      localparam int  LSB   = (STAGE_WORDS - 1 - w) * WORD_W;
      localparam int  WID   = (w == 0) ? TOP_W : WORD_W;
      localparam bit  IS_AD = (w == 1);
      localparam logic [WORD_W-1:0] KEEP = {WORD_W{1'b1}} >> (WORD_W - WID);

      logic [WORD_W-1:0] k_q, m_q;
      logic              kwe, mwe;

      assign kwe = sw_we && !sw_word[2] && (sw_word[1:0] == 2'(w));
      assign mwe = sw_we &&  sw_word[2] && (sw_word[1:0] == 2'(w));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            k_q <= '0;
            m_q <= '0;
         end else if (load_km) begin
            k_q <= WORD_W'(load_key[LSB +: WID]);
            m_q <= WORD_W'(load_mask[LSB +: WID]);
         end else if (load_ad && IS_AD) begin
            k_q <= load_data;
         end else begin
            if (kwe) k_q <= sw_wdata & KEEP;
            if (mwe) m_q <= sw_wdata & KEEP;
         end
      end

      assign kview[w]              = k_q;
      assign mview[w]              = m_q;
      assign key_flat[LSB +: WID]  = k_q[WID-1:0];
      assign mask_flat[LSB +: WID] = m_q[WID-1:0];
   end

   assign ad_word  = kview[1];
   assign sw_rdata = sw_word[2] ? mview[sw_word[1:0]] : kview[sw_word[1:0]];

   AST_TOP_WORD_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
      ((kview[0] >> TOP_W) == '0) && ((mview[0] >> TOP_W) == '0)) else $error("top staging word grew"); // R1

   AST_LOAD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(load_km && load_ad)) else $error("two staging loads at once"); // R4

   AST_LOAD_NOT_WITH_SW: assert property (@(posedge clk) disable iff (!rst_n)
      (load_km || load_ad) |-> !sw_we) else $error("software write during command"); // R9

endmodule

// File: rtl/tcam_store.sv
module tcam_store #(
   parameter int ENTRIES = 128,
   parameter int KEY_W   = 200,
   parameter int DATA_W  = 64,
   parameter int IDX_W   = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_km,
   input  logic              wr_ad,
   input  logic [IDX_W-1:0]  acc_idx,
   input  logic [KEY_W-1:0]  wr_key,
   input  logic [KEY_W-1:0]  wr_mask,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [KEY_W-1:0]  cmp_key,
   output logic [KEY_W-1:0]  rd_key,
   output logic [KEY_W-1:0]  rd_mask,
   output logic [DATA_W-1:0] rd_data,
   output logic              match
);
   localparam int SEL_W = $clog2(ENTRIES);

   logic [KEY_W-1:0]  ent_key  [ENTRIES];
   logic [KEY_W-1:0]  ent_mask [ENTRIES];
   logic [DATA_W-1:0] ent_data [ENTRIES];
   logic [ENTRIES-1:0] ent_valid;

   logic             in_rng;
   logic [SEL_W-1:0] sel;

   assign in_rng = 32'(acc_idx) < ENTRIES;
   assign sel    = acc_idx[SEL_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int e = 0; e < ENTRIES; e++) begin
            ent_key[e]  <= '0;
            ent_mask[e] <= '0;
            ent_data[e] <= '0;
         end
         ent_valid <= '0;
      end else begin
         if (wr_km && in_rng) begin
            ent_key[sel]   <= wr_key;
            ent_mask[sel]  <= wr_mask;
            ent_valid[sel] <= 1'b1;
         end
         if (wr_ad && in_rng) begin
            ent_data[sel] <= wr_data;
         end
      end
   end

   assign rd_key  = in_rng ? ent_key[sel]  : '0;
   assign rd_mask = in_rng ? ent_mask[sel] : '0;
   assign rd_data = in_rng ? ent_data[sel] : '0;
   assign match   = in_rng && ent_valid[sel] &&
                    (((ent_key[sel] ^ cmp_key) & ent_mask[sel]) == '0);

   AST_WRITE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_km && wr_ad)) else $error("two table writes at once"); // R8

   AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((ent_valid & $past(ent_valid)) == $past(ent_valid))) else $error("entry lost validity"); // R4

endmodule

// File: rtl/tcam_seq.sv
module tcam_seq #(
   parameter int ENTRIES = 128,
   parameter int IDX_W   = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctrl_we,
   input  logic [63:0]      ctrl_wdata,
   input  logic             ent_match,
   output logic [IDX_W-1:0] acc_idx,
   output logic [IDX_W-1:0] idx_q,
   output logic [2:0]       op_q,
   output logic             done,
   output logic             hit,
   output logic             busy,
   output logic             wr_km,
   output logic             wr_ad,
   output logic             load_km,
   output logic             load_ad
);
   import tcam_pkg::*;

   localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

   sq_state_e        state;
   tcam_op_e         op_r;
   logic [IDX_W-1:0] scan;
   logic [2:0]       new_op;
   logic             start, in_rng, exec;

   assign new_op = ctrl_wdata[CW_OP_LSB +: CW_OP_W];
   assign busy   = (state != SQ_IDLE);
   assign start  = ctrl_we && !busy && op_known(new_op);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SQ_IDLE;
         op_r  <= OP_PUT_KM;
         idx_q <= '0;
         scan  <= '0;
         done  <= 1'b1;
         hit   <= 1'b0;
      end else begin
         case (state)
            SQ_IDLE: begin
               if (start) begin
                  op_r  <= tcam_op_e'(new_op);
                  idx_q <= ctrl_wdata[IDX_W-1:0];
                  scan  <= '0;
                  done  <= 1'b0;
                  hit   <= 1'b0;
                  state <= (new_op == OP_LOOKUP) ? SQ_SCAN : SQ_EXEC;
               end
            end
            SQ_EXEC: begin
               done  <= 1'b1;
               state <= SQ_IDLE;
            end
            SQ_SCAN: begin
               if (ent_match) begin
                  hit   <= 1'b1;
                  idx_q <= scan;
                  done  <= 1'b1;
                  state <= SQ_IDLE;
               end else if (scan == LAST) begin
                  hit   <= 1'b0;
                  idx_q <= '0;
                  done  <= 1'b1;
                  state <= SQ_IDLE;
               end else begin
                  scan <= scan + 1'b1;
               end
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end

   assign in_rng  = 32'(idx_q) < ENTRIES;
   assign exec    = (state == SQ_EXEC) && in_rng;
   assign wr_km   = exec && (op_r == OP_PUT_KM);
   assign wr_ad   = exec && (op_r == OP_PUT_AD);
   assign load_km = exec && (op_r == OP_GET_KM);
   assign load_ad = exec && (op_r == OP_GET_AD);
   assign acc_idx = (state == SQ_SCAN) ? scan : idx_q;
   assign op_q    = op_r;

   AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (!done && !hit)) else $error("start left done or hit set"); // R12

   AST_BUSY_HOLDS_OP: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(op_r)) else $error("opcode changed mid-command"); // R9

   AST_HIT_FROM_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hit) |-> $past(state == SQ_SCAN)) else $error("hit outside search"); // R6

   AST_SCAN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SQ_SCAN && $past(state == SQ_SCAN)) |-> (scan == $past(scan) + 1'b1)) else $error("scan skipped"); // R7

   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy) else $error("done while busy"); // R12

endmodule

// File: rtl/tcam_cmd_ctrl.sv
module tcam_cmd_ctrl #(
   parameter int ENTRIES = 128,
   parameter int IDX_W   = 10,
   parameter int KEY_W   = 200,
   parameter int ADDR_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_we,
   input  logic [63:0]       reg_wdata,
   output logic [63:0]       reg_rdata
);
   import tcam_pkg::*;

   localparam int WORD_W = 64;

   if (KEY_W <= 3 * WORD_W || KEY_W > 4 * WORD_W) begin : g_bad_key
      $error("KEY_W must lie in 193..256");
   end
   if (ENTRIES < 2 || ENTRIES > (1 << IDX_W)) begin : g_bad_depth
      $error("ENTRIES must lie in 2..2**IDX_W");
   end
   if (IDX_W > CW_HIT_BIT) begin : g_bad_idx
      $error("IDX_W overlaps control flags");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("ADDR_W too small for the register map");
   end

   logic              is_stage, is_ctrl, busy;
   logic              wr_km, wr_ad, load_km, load_ad, ent_match, done, hit;
   logic [IDX_W-1:0]  acc_idx, idx_q;
   logic [2:0]        op_q;
   logic [KEY_W-1:0]  key_flat, mask_flat, rd_key, rd_mask;
   logic [WORD_W-1:0] ad_word, rd_data, stage_rdata, ctrl_word;

   assign is_stage = 32'(reg_addr) < 2 * STAGE_WORDS;
   assign is_ctrl  = 32'(reg_addr) == CTRL_ADDR;

   tcam_stage #(.KEY_W(KEY_W), .WORD_W(WORD_W)) u_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .sw_we    (reg_we && is_stage && !busy),
      .sw_word  (reg_addr[2:0]),
      .sw_wdata (reg_wdata),
      .load_km  (load_km),
      .load_key (rd_key),
      .load_mask(rd_mask),
      .load_ad  (load_ad),
      .load_data(rd_data),
      .key_flat (key_flat),
      .mask_flat(mask_flat),
      .ad_word  (ad_word),
      .sw_rdata (stage_rdata)
   );

   tcam_store #(.ENTRIES(ENTRIES), .KEY_W(KEY_W), .DATA_W(WORD_W), .IDX_W(IDX_W)) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_km  (wr_km),
      .wr_ad  (wr_ad),
      .acc_idx(acc_idx),
      .wr_key (key_flat),
      .wr_mask(mask_flat),
      .wr_data(ad_word),
      .cmp_key(key_flat),
      .rd_key (rd_key),
      .rd_mask(rd_mask),
      .rd_data(rd_data),
      .match  (ent_match)
   );

   tcam_seq #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctrl_we   (reg_we && is_ctrl),
      .ctrl_wdata(reg_wdata),
      .ent_match (ent_match),
      .acc_idx   (acc_idx),
      .idx_q     (idx_q),
      .op_q      (op_q),
      .done      (done),
      .hit       (hit),
      .busy      (busy),
      .wr_km     (wr_km),
      .wr_ad     (wr_ad),
      .load_km   (load_km),
      .load_ad   (load_ad)
   );

   always_comb begin
      ctrl_word                           = '0;
      ctrl_word[IDX_W-1:0]                = idx_q;
      ctrl_word[CW_HIT_BIT]               = hit;
      ctrl_word[CW_DONE_BIT]              = done;
      ctrl_word[CW_OP_LSB +: CW_OP_W]     = op_q;
   end

   assign reg_rdata = is_stage ? stage_rdata : (is_ctrl ? ctrl_word : '0);

   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_stage && !is_ctrl) |-> (reg_rdata == '0)) else $error("unmapped read nonzero"); // R1

   AST_CTRL_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      is_ctrl |-> ((reg_rdata >> (CW_OP_LSB + CW_OP_W)) == '0)) else $error("spare control bits set"); // R2

endmodule

// File: tb/tb_tcam_cmd_ctrl.sv
module tb_tcam_cmd_ctrl;

   localparam int ENT   = 16;
   localparam int IDX_W = 10;
   localparam int KW    = 200;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [63:0] reg_wdata = '0;
   logic [63:0] reg_rdata;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   logic [KW-1:0] m_key  [ENT];
   logic [KW-1:0] m_mask [ENT];
   logic [63:0]   m_data [ENT];
   bit            m_valid[ENT];

   always #4 clk = ~clk;

   tcam_cmd_ctrl #(.ENTRIES(ENT), .IDX_W(IDX_W), .KEY_W(KW), .ADDR_W(4)) dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
   );

   task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [KW-1:0] rnd_key();
      logic [223:0] t;
      t = {$urandom(), $urandom(), $urandom(), $urandom(), $urandom(), $urandom(), $urandom()};
      return t[KW-1:0];
   endfunction

   function automatic int model_search(input logic [KW-1:0] k);
      for (int e = 0; e < ENT; e++)
         if (m_valid[e] && (((m_key[e] ^ k) & m_mask[e]) == '0)) return e;
      return -1;
   endfunction

   function automatic logic [63:0] ctrl_val(input logic [2:0] op, input bit dn, input bit ht, input int idx);
      return (64'(op) << 18) | (64'(dn) << 17) | (64'(ht) << 16) | 64'(idx);
   endfunction

   task automatic reg_write(input logic [3:0] a, input logic [63:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic reg_read(input logic [3:0] a, output logic [63:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic stage_key(input logic [KW-1:0] k);
      reg_write(0, 64'(k[199:192]));
      reg_write(1, k[191:128]);
      reg_write(2, k[127:64]);
      reg_write(3, k[63:0]);
   endtask

   task automatic stage_mask(input logic [KW-1:0] m);
      reg_write(4, 64'(m[199:192]));
      reg_write(5, m[191:128]);
      reg_write(6, m[127:64]);
      reg_write(7, m[63:0]);
   endtask

   task automatic wait_done(output int lat);
      logic [63:0] v;
      lat = 0;
      reg_read(8, v);
      while (!v[17] && lat < 1000) begin
         @(negedge clk);
         lat++;
         reg_read(8, v);
      end
   endtask

   task automatic cmd(input logic [2:0] op, input int idx, output int lat);
      reg_write(8, (64'(op) << 18) | 64'(idx));
      wait_done(lat);
   endtask

   task automatic read_staged(output logic [KW-1:0] k, output logic [KW-1:0] m);
      logic [63:0] w0, w1, w2, w3;
      reg_read(0, w0); reg_read(1, w1); reg_read(2, w2); reg_read(3, w3);
      k = {w0[7:0], w1, w2, w3};
      reg_read(4, w0); reg_read(5, w1); reg_read(6, w2); reg_read(7, w3);
      m = {w0[7:0], w1, w2, w3};
   endtask

   task automatic put_entry(input int idx, input logic [KW-1:0] k, input logic [KW-1:0] m);
      int lat;
      stage_key(k);
      stage_mask(m);
      cmd(3'b000, idx, lat);
      check("R7", "write latency", 64'(lat), 64'd1);
      if (idx < ENT) begin
         m_key[idx] = k; m_mask[idx] = m; m_valid[idx] = 1;
      end
   endtask

   task automatic search(input logic [KW-1:0] k, input string tag);
      int lat, e;
      logic [63:0] v;
      stage_key(k);
      cmd(3'b010, 0, lat);
      e = model_search(k);
      reg_read(8, v);
      check("R6", {tag, " search result"}, v,
            ctrl_val(3'b010, 1, e >= 0, (e >= 0) ? e : 0));
      check("R7", {tag, " search latency"}, 64'(lat), 64'((e >= 0) ? e + 1 : ENT));
   endtask

   initial begin
      #(8 * 150000);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [63:0] v, v0;
      logic [KW-1:0] k, m, kq;
      int lat;
      void'($urandom(32'h5EED_0A17));
      for (int e = 0; e < ENT; e++) begin
         m_key[e] = '0; m_mask[e] = '0; m_data[e] = '0; m_valid[e] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R3 reset state
      reg_read(8, v);
      check("R3", "control after reset", v, ctrl_val(3'b000, 1, 0, 0));
      v0 = '0;
      for (int a = 0; a < 8; a++) begin
         reg_read(4'(a), v);
         v0 = v0 | v;
      end
      check("R3", "staging after reset", v0, 64'd0);
      search('0, "R3 all-zero key after reset");

      // R1 layout and unmapped words
      reg_write(0, '1);
      reg_read(0, v);
      check("R1", "key word 0 width", v, 64'hFF);
      reg_write(4, '1);
      reg_read(4, v);
      check("R1", "mask word 0 width", v, 64'hFF);
      reg_write(12, 64'h5555_AAAA_5555_AAAA);
      reg_read(12, v);
      check("R1", "unmapped word", v, 64'd0);
      reg_read(9, v);
      check("R1", "unmapped word 9", v, 64'd0);

      // R11 out-of-range index
      k = rnd_key();
      put_entry(20, k, '1);
      search(k, "R11 after out-of-range write");
      reg_write(1, 64'hC0DE_0000_1111_2222);
      cmd(3'b001, 20, lat);
      reg_read(1, v);
      check("R11", "staging after out-of-range read", v, 64'hC0DE_0000_1111_2222);
      check("R7", "read latency", 64'(lat), 64'd1);

      // R5 and R7 last entry; R6 priority
      k = rnd_key();
      put_entry(ENT - 1, k, '1);
      search(k, "R7 last entry");
      search(k ^ (KW'(1) << 77), "R5 one care bit differs");
      m = '1;
      m[40:0] = '0;
      put_entry(7, k ^ KW'(41'h1_2345_6789), m);
      search(k, "R5 don't-care bits");
      search(k, "R6 lowest wins");

      // R12 start clears done and hit
      reg_write(8, ctrl_val(3'b010, 0, 0, 0));
      reg_read(8, v);
      check("R12", "flags right after start", 64'(v[17:16]), 64'd0);
      wait_done(lat);

      // R4 readback
      stage_key('0); stage_mask('0);
      cmd(3'b001, ENT - 1, lat);
      read_staged(kq, m);
      check("R4", "readback key low", kq[63:0], k[63:0]);
      check("R4", "readback key top", 64'(kq[199:128] == k[199:128]), 64'd1);
      check("R4", "readback mask", 64'(m == '1), 64'd1);
      reg_read(0, v);
      check("R1", "word 0 upper bits after load", v >> 8, 64'd0);

      // R8 associated data
      reg_write(1, 64'hA5A5_1234_5678_9ABC);
      cmd(3'b100, 4, lat);
      reg_write(1, 64'd0);
      reg_write(0, 64'h3C);
      cmd(3'b101, 4, lat);
      reg_read(1, v);
      check("R8", "data returned in word 1", v, 64'hA5A5_1234_5678_9ABC);
      reg_read(0, v);
      check("R8", "word 0 untouched", v, 64'h3C);

      // R10 unlisted opcodes
      reg_read(8, v0);
      reg_write(8, ctrl_val(3'b011, 0, 0, 5));
      reg_read(8, v);
      check("R10", "opcode 011 no effect", v, v0);
      reg_write(8, ctrl_val(3'b111, 0, 0, 9));
      reg_read(8, v);
      check("R10", "opcode 111 no effect", v, v0);
      check("R2", "control word layout", v0, ctrl_val(3'b101, 1, 0, 4));

      // random fill and searches
      for (int e = 0; e < ENT; e++) begin
         if (e == 7) continue;
         put_entry(e, rnd_key(), rnd_key() | rnd_key() | rnd_key());
      end
      for (int t = 0; t < 40; t++) begin
         if ($urandom_range(1, 0) == 1) begin
            int e = $urandom_range(ENT - 1, 0);
            k = m_key[e] ^ (rnd_key() & ~m_mask[e]);
         end else begin
            k = rnd_key();
         end
         search(k, "R5 random");
      end

      // R9 writes during a command are ignored
      kq = rnd_key();
      for (int t = 0; t < 50 && model_search(kq) >= 0; t++) kq = rnd_key();
      stage_key(kq);
      reg_write(8, ctrl_val(3'b010, 0, 0, 0));
      reg_write(8, ctrl_val(3'b000, 0, 0, 3));
      reg_write(3, 64'hDEAD_BEEF_DEAD_BEEF);
      wait_done(lat);
      reg_read(8, v);
      check("R9", "result after busy writes", v, ctrl_val(3'b010, 1, 0, 0));
      reg_read(3, v);
      check("R9", "staging word kept", v, kq[63:0]);
      cmd(3'b001, 3, lat);
      read_staged(k, m);
      check("R9", "entry 3 key kept", 64'(k == m_key[3]), 64'd1);
      check("R9", "entry 3 mask kept", 64'(m == m_mask[3]), 64'd1);

      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule